// File: doc/BRIEF.md
# Extended Display Mode Register File

This block holds the mode registers of a linear-framebuffer display. A host selects a register by writing its number to an index port. It then reads or writes that register's 16-bit value through a data port. Writes are not simply stored. Each value is checked against the codes the register accepts, and values outside that set are dropped without any error response. From the stored values the block derives the bank offset and the line pitch in bytes.

When the enable bit goes from 0 to 1, the block performs a one-time mode setup. The virtual size registers are loaded from the resolution, the panning offsets and the start address are cleared, and the line pitch is computed. The block also sends a one-cycle request to an external memory-clear engine, unless the host has asked it not to. A capability-query bit makes reads of the resolution and depth registers return the largest supported values in place of the stored ones.

Register numbers (index values): 0 identity, 1 horizontal resolution, 2 vertical resolution, 3 bits per pixel, 4 enable, 5 bank, 6 virtual width, 7 virtual height, 8 horizontal offset, 9 vertical offset.

Enable register bits: bit 0 enable, bit 1 capability query, bit 5 8-bit DAC, bit 7 skip memory clear.

Top module: `xmode_regs`

## Requirements
- R1: After reset every register reads 0, except bits per pixel, which reads 8. At reset `clr_req` and `dac8` are 0.
- R2: `dat_rdata` always shows the register selected by the most recent index write. For an index above 9 it reads 0, and a data write there changes nothing.
- R3: While enable bit 1 is set, reads of index 1, 2 and 3 return MAX_XRES, MAX_YRES and MAX_BPP. Every other index reads its stored value, and the `xres`, `yres` and `bpp` outputs keep the stored values.
- R4: A write to index 0 is stored only if the value is one of 0xB0C0, 0xB0C1, 0xB0C2, 0xB0C3 or 0xB0C4. Any other value leaves the register unchanged.
- R5: A write to index 3 of 0 stores 8. A write of 4, 8, 15, 16, 24 or 32 is stored as written. Any other value is ignored.
- R6: A write to index 5 stores the value ANDed with BANK_MASK, or with BANK_MASK>>2 when the stored bpp is 4. `bank_off` equals the stored bank shifted left by 16 and changes only on a bank write.
- R7: Mode setup runs only when a write to index 4 sets bit 0 while the stored bit 0 is 0. A write that finds bit 0 already set repeats none of the setup effects.
- R8: On setup, virtual width takes the horizontal resolution, virtual height takes the vertical resolution, and both offsets and `start_addr` become 0.
- R9: On setup, `line_pitch` becomes xres/2 when bpp is 4, and xres*((bpp+7)/8) otherwise. It changes only on setup.
- R10: On setup, `clr_req` pulses high for exactly one cycle, on the cycle after the write, unless bit 7 of the written value is set. `dac8` takes bit 5 of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Index write strobe |
| idx_wdata | input | 16 | Register number to select |
| dat_we | input | 1 | Data write strobe for the selected register |
| dat_wdata | input | 16 | Data write value |
| dat_rdata | output | 16 | Read value of the selected register |
| xres | output | 16 | Stored horizontal resolution |
| yres | output | 16 | Stored vertical resolution |
| bpp | output | 16 | Stored bits per pixel |
| line_pitch | output | LP_W | Bytes per scan line |
| start_addr | output | SA_W | Display start address |
| bank_off | output | 32 | Bank window byte offset |
| dac8 | output | 1 | 8-bit DAC mode |
| clr_req | output | 1 | One-cycle memory clear request |

## Verification
Several rules are checked as properties on every cycle:
- the clear request is a single-cycle pulse and appears only after an enabling write that does not suppress the clear;
- the stored depth is always a legal code;
- the bank offset and the line pitch move only after writes to their own registers;
- reads beyond the last index give 0.

Only the directed scenarios can show the arithmetic results: the exact pitch for each depth, the masked bank values, the capability readout, the ID filtering, and the contents of the virtual-size and offset registers after setup.

// File: rtl/xmode_regs.sv
module xmode_regs #(
  parameter int          LP_W      = 20,
  parameter int          SA_W      = 32,
  parameter logic [15:0] BANK_MASK = 16'h000F,
  parameter logic [15:0] MAX_XRES  = 16'd1600,
  parameter logic [15:0] MAX_YRES  = 16'd1200,
  parameter logic [15:0] MAX_BPP   = 16'd32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idx_we,
  input  logic [15:0]     idx_wdata,
  input  logic            dat_we,
  input  logic [15:0]     dat_wdata,
  output logic [15:0]     dat_rdata,
  output logic [15:0]     xres,
  output logic [15:0]     yres,
  output logic [15:0]     bpp,
  output logic [LP_W-1:0] line_pitch,
  output logic [SA_W-1:0] start_addr,
  output logic [31:0]     bank_off,
  output logic            dac8,
  output logic            clr_req
);
  localparam logic [15:0] IX_ID = 0, IX_XR = 1, IX_YR = 2, IX_BPP = 3, IX_EN = 4,
                          IX_BANK = 5, IX_VW = 6, IX_VH = 7, IX_XO = 8, IX_YO = 9;
  localparam logic [15:0] IX_LAST = IX_YO;
  localparam int EB_ON = 0, EB_CAPS = 1, EB_DAC = 5, EB_NOCLR = 7;

  logic [15:0] idx_q, id_q, en_q, bank_q, vw_q, vh_q, xo_q, yo_q;
  logic [15:0] bpp_wv, bank_wv;
  logic        bpp_ok, id_ok, wr, setup;
  logic [2:0]  bytes_pp;
  logic [LP_W-1:0] pitch_calc;

  assign wr      = dat_we && idx_q <= IX_LAST;
  assign bpp_wv  = (dat_wdata == 16'd0) ? 16'd8 : dat_wdata;
  assign bpp_ok  = bpp_wv inside {16'd4, 16'd8, 16'd15, 16'd16, 16'd24, 16'd32};
  assign id_ok   = dat_wdata inside {[16'hB0C0:16'hB0C4]};
  assign bank_wv = dat_wdata & ((bpp == 16'd4) ? (BANK_MASK >> 2) : BANK_MASK);
  assign setup   = wr && idx_q == IX_EN && dat_wdata[EB_ON] && !en_q[EB_ON];
  assign bytes_pp   = 3'((bpp + 16'd7) >> 3);
  assign pitch_calc = (bpp == 16'd4) ? LP_W'(xres >> 1) : LP_W'(xres) * LP_W'(bytes_pp);
  assign bank_off   = {bank_q, 16'h0000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0; id_q <= '0; xres <= '0; yres <= '0; bpp <= 16'd8;
      en_q <= '0; bank_q <= '0; vw_q <= '0; vh_q <= '0; xo_q <= '0; yo_q <= '0;
      line_pitch <= '0; start_addr <= '0; dac8 <= 1'b0; clr_req <= 1'b0;
    end else begin
      clr_req <= 1'b0;
      if (idx_we) idx_q <= idx_wdata;
      if (wr) begin
        case (idx_q)
          IX_ID:   if (id_ok) id_q <= dat_wdata;
          IX_XR:   xres <= dat_wdata;
          IX_YR:   yres <= dat_wdata;
          IX_BPP:  if (bpp_ok) bpp <= bpp_wv;
          IX_EN:   en_q <= dat_wdata;
          IX_BANK: bank_q <= bank_wv;
          IX_VW:   vw_q <= dat_wdata;
          IX_VH:   vh_q <= dat_wdata;
          IX_XO:   xo_q <= dat_wdata;
          IX_YO:   yo_q <= dat_wdata;
          default: ;
        endcase
      end
      if (setup) begin
        vw_q <= xres;
        vh_q <= yres;
        xo_q <= '0;
        yo_q <= '0;
        start_addr <= '0;
        line_pitch <= pitch_calc;
        clr_req <= !dat_wdata[EB_NOCLR];
        dac8 <= dat_wdata[EB_DAC];
      end
    end
  end

  always_comb begin
    case (idx_q)
      IX_ID:   dat_rdata = id_q;
      IX_XR:   dat_rdata = en_q[EB_CAPS] ? MAX_XRES : xres;
      IX_YR:   dat_rdata = en_q[EB_CAPS] ? MAX_YRES : yres;
      IX_BPP:  dat_rdata = en_q[EB_CAPS] ? MAX_BPP : bpp;
      IX_EN:   dat_rdata = en_q;
      IX_BANK: dat_rdata = bank_q;
      IX_VW:   dat_rdata = vw_q;
      IX_VH:   dat_rdata = vh_q;
      IX_XO:   dat_rdata = xo_q;
      IX_YO:   dat_rdata = yo_q;
      default: dat_rdata = '0;
    endcase
  end
endmodule

module xmode_regs_chk #(
  parameter int LP_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dat_we,
  input logic [15:0]     dat_wdata,
  input logic [15:0]     idx_q,
  input logic [15:0]     en_q,
  input logic [15:0]     dat_rdata,
  input logic [15:0]     bpp,
  input logic [31:0]     bank_off,
  input logic [LP_W-1:0] line_pitch,
  input logic            clr_req
);
  // R10
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !clr_req);
  // R10
  clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && idx_q == 16'd4 && dat_wdata[0] && !dat_wdata[7] && !en_q[0]) |=> clr_req);
  // R7
  clr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_we && idx_q == 16'd4 && !en_q[0]) |=> !clr_req);
  // R5
  bpp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bpp inside {16'd4, 16'd8, 16'd15, 16'd16, 16'd24, 16'd32});
  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_we && idx_q == 16'd5) |=> $stable(bank_off));
  // R9
  pitch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_we && idx_q == 16'd4) |=> $stable(line_pitch));
  // R2
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q > 16'd9 |-> dat_rdata == 16'd0);
endmodule

bind xmode_regs xmode_regs_chk #(.LP_W(LP_W)) i_xmode_regs_chk (
  .clk(clk), .rst_n(rst_n), .dat_we(dat_we), .dat_wdata(dat_wdata),
  .idx_q(idx_q), .en_q(en_q), .dat_rdata(dat_rdata), .bpp(bpp),
  .bank_off(bank_off), .line_pitch(line_pitch), .clr_req(clr_req));

// File: tb/test_xmode_regs.sv
module test_xmode_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        idx_we = 1'b0, dat_we = 1'b0;
  logic [15:0] idx_wdata = '0, dat_wdata = '0;
  logic [15:0] dat_rdata, xres, yres, bpp;
  logic [19:0] line_pitch;
  logic [31:0] start_addr, bank_off;
  logic        dac8, clr_req;
  int tests = 0, fails = 0;
  logic last_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmode_regs i_xmode_regs (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .xres(xres), .yres(yres), .bpp(bpp), .line_pitch(line_pitch),
    .start_addr(start_addr), .bank_off(bank_off), .dac8(dac8), .clr_req(clr_req));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sel(input logic [15:0] i);
    @(negedge clk); idx_we = 1'b1; idx_wdata = i;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic put(input logic [15:0] i, input logic [15:0] v);
    sel(i);
    dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
    last_clr = clr_req;
  endtask

  task automatic rd_chk(string req, input logic [15:0] i, input logic [15:0] exp);
    sel(i);
    check(req, dat_rdata, exp);
  endtask

  task automatic t_reset;
    check("R1 bpp out", bpp, 16'd8);
    check("R1 xres out", xres, 0);
    check("R1 clr", clr_req, 0);
    check("R1 dac8", dac8, 0);
    rd_chk("R1 id", 0, 0);
    rd_chk("R1 bpp read", 3, 8);
    rd_chk("R1 enable", 4, 0);
  endtask

  task automatic t_id;
    put(0, 16'hB0C2); rd_chk("R4 id valid", 0, 16'hB0C2);
    put(0, 16'h1234); rd_chk("R4 id invalid", 0, 16'hB0C2);
    put(0, 16'hB0C5); rd_chk("R4 id above range", 0, 16'hB0C2);
    put(0, 16'hB0C4); rd_chk("R4 id last", 0, 16'hB0C4);
  endtask

  task automatic t_bpp;
    put(3, 16); check("R5 bpp 16", bpp, 16);
    put(3, 12); check("R5 bpp 12 ignored", bpp, 16);
    put(3, 0);  check("R5 bpp 0 as 8", bpp, 8);
    put(3, 24); rd_chk("R5 bpp 24", 3, 24);
    put(3, 33); check("R5 bpp 33 ignored", bpp, 24);
    put(3, 8);
  endtask

  task automatic t_bank;
    put(5, 16'h00FF); check("R6 bank off 8bpp", bank_off, 32'h000F_0000);
    rd_chk("R6 bank read", 5, 16'h000F);
    put(3, 4);
    put(5, 16'h00FF); check("R6 bank off 4bpp", bank_off, 32'h0003_0000);
    put(3, 8);
    check("R6 bank holds", bank_off, 32'h0003_0000);
  endtask

  task automatic t_oob;
    put(10, 16'hFFFF);
    check("R2 oob read", dat_rdata, 0);
    check("R2 oob no effect", bpp, 8);
    rd_chk("R2 high index", 16'hFFFF, 0);
    rd_chk("R2 id intact", 0, 16'hB0C4);
  endtask

  task automatic t_enable;
    put(1, 640); put(2, 480); put(3, 16);
    put(6, 1); put(8, 5); put(9, 7);
    put(4, 16'h0021);
    check("R10 clr pulse", last_clr, 1);
    @(negedge clk); check("R10 clr one cycle", clr_req, 0);
    check("R9 pitch 16bpp", line_pitch, 1280);
    check("R10 dac8 set", dac8, 1);
    check("R8 start", start_addr, 0);
    rd_chk("R8 virt w", 6, 640);
    rd_chk("R8 virt h", 7, 480);
    rd_chk("R8 x off", 8, 0);
    rd_chk("R8 y off", 9, 0);
  endtask

  task automatic t_reenable;
    put(1, 800); put(6, 3);
    put(4, 16'h0001);
    check("R7 no second clr", last_clr, 0);
    check("R7 pitch kept", line_pitch, 1280);
    check("R7 dac8 kept", dac8, 1);
    rd_chk("R7 virt w kept", 6, 3);
  endtask

  task automatic t_noclear;
    put(4, 0);
    put(3, 4);
    put(4, 16'h0081);
    check("R10 noclear", last_clr, 0);
    @(negedge clk); check("R10 noclear later", clr_req, 0);
    check("R9 pitch 4bpp", line_pitch, 400);
    check("R10 dac8 clear", dac8, 0);
    rd_chk("R8 virt w 800", 6, 800);
    put(4, 0); put(3, 24); put(1, 100);
    put(4, 1);
    check("R10 clr 24bpp", last_clr, 1);
    check("R9 pitch 24bpp", line_pitch, 300);
    put(4, 0); put(3, 15);
    put(4, 1);
    check("R9 pitch 15bpp", line_pitch, 200);
  endtask

  task automatic t_caps;
    put(4, 16'h0003);
    check("R3 no setup", last_clr, 0);
    rd_chk("R3 max x", 1, 1600);
    rd_chk("R3 max y", 2, 1200);
    rd_chk("R3 max bpp", 3, 32);
    rd_chk("R3 other reg", 7, 480);
    check("R3 xres out", xres, 100);
    check("R3 bpp out", bpp, 15);
    put(4, 16'h0001);
    rd_chk("R3 normal x", 1, 100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_id; t_bpp; t_bank; t_oob; t_enable; t_reenable; t_noclear; t_caps;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule